// File: doc/BRIEF.md
# Multi-Channel DMA Request Controller

This block keeps the programming state of a set of DMA channels and decides, request by request, whether a device transfer may go ahead. Software programs each channel through a 32-bit register port. It sets an enable bit, a direction bit, a remaining byte count and a memory address.

A device asks for a transfer by giving a channel number, a length and a direction. The block checks the request against the channel's programming. When the request is consistent, the block cuts the length down to the remaining count and starts one burst on a simple memory port. When the burst completes, it writes the outcome back into the channel. A request that is not consistent moves no data. Instead it flags a memory error in the channel and sets the channel's bit in a sticky error-source register, which feeds a non-maskable interrupt.

Only one request is in service at a time. The address sent to memory is the untranslated value that software programmed into the channel.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Channel c (0 to 7) word k sits at byte offset 0x100 + 0x20·c + 8·k. Here k=1 is control/status, k=2 is the remaining byte count and k=3 is the memory address. Register reads are combinational. Word k=0 and unmapped offsets read as zero, and writes to them change nothing.
- R2: While reset is low, every channel register and the error-source register read as zero, and busy_o and mem_valid_o are low.
- R3: Control bits are: bit 0 enable, bit 1 direction (1 = memory to device), bit 8 transfer complete, bit 9 memory error, bit 10 address error. Bits 8, 9 and 10 of the requested channel are cleared on the clock edge that accepts a request.
- R4: A request to a channel whose enable bit is 0 sets control bit 9 and bit c of the error-source register. It starts no burst.
- R5: A request whose direction does not match the channel sets control bit 9 and error-source bit c, and starts no burst. Direction matches when req_to_mem_i = 1 with control bit 1 = 0, or when req_to_mem_i = 0 with control bit 1 = 1.
- R6: The burst length mem_len_o is the smaller of req_len_i and the channel's count register.
- R7: mem_addr_o equals the channel's address register at acceptance and holds steady during the burst. A transfer never changes the address register.
- R8: The edge on which mem_done_i is high during a burst sets control bit 8 and lowers the count register by the burst length.
- R9: busy_o and mem_valid_o rise on the edge that accepts a valid request and fall on the edge that samples mem_done_i. A request presented while busy_o is high is ignored.
- R10: The error-source register reads at offset 0x200, with bit c standing for channel c. Its bits stay set until reset, and register writes to 0x200 have no effect.
- R11: mem_write_o is 1 for a device-to-memory burst (req_to_mem_i = 1) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (12) | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| req_valid_i | input | 1 | Device transfer request |
| req_chan_i | input | 3 | Requesting channel |
| req_len_i | input | 32 | Requested length in bytes |
| req_to_mem_i | input | 1 | 1 = device to memory, 0 = memory to device |
| busy_o | output | 1 | A request is in service |
| mem_valid_o | output | 1 | Memory burst in progress |
| mem_addr_o | output | 32 | Burst start address |
| mem_len_o | output | 32 | Burst length in bytes |
| mem_write_o | output | 1 | Burst writes memory |
| mem_done_i | input | 1 | Burst complete |

## Verification
The register reads are combinational, so the bench samples read data 1 ns after it sets the offset. A request is driven on a falling edge and is taken on the next rising edge. The bench checks busy, the memory port, the cleared status bits and any error flags at the following falling edge, one cycle after the request. The completion pulse works the same way: the control and count write-back is checked one cycle after mem_done_i is driven. The bench never samples while the edge that acts on a stimulus is still ahead of it.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_DIR  = 1;
  localparam int unsigned CTRL_TC   = 8;
  localparam int unsigned CTRL_MERR = 9;
  localparam int unsigned CTRL_AERR = 10;

  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << CTRL_TC) | (DATA_W'(1) << CTRL_MERR) | (DATA_W'(1) << CTRL_AERR);

  localparam logic [1:0] IDX_CTRL  = 2'd1;
  localparam logic [1:0] IDX_COUNT = 2'd2;
  localparam logic [1:0] IDX_ADDR  = 2'd3;

  typedef struct packed {
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] addr;
  } chan_regs_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [CW-1:0]     sw_chan_i,
  input  logic [1:0]        sw_idx_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              eng_we_i,
  input  logic [CW-1:0]     eng_chan_i,
  input  logic [DATA_W-1:0] eng_ctrl_i,
  input  logic [DATA_W-1:0] eng_count_i,
  output chan_regs_t        regs_o [NUM_CH]
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sw_hit, eng_hit;
    assign sw_hit  = sw_we_i  && (sw_chan_i  == CW'(g));
    assign eng_hit = eng_we_i && (eng_chan_i == CW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else begin
        // engine owns ctrl/count on a collision; addr is software-only
        if (eng_hit) begin
          regs_o[g].ctrl  <= eng_ctrl_i;
          regs_o[g].count <= eng_count_i;
        end else if (sw_hit) begin
          if (sw_idx_i == IDX_CTRL)  regs_o[g].ctrl  <= sw_wdata_i;
          if (sw_idx_i == IDX_COUNT) regs_o[g].count <= sw_wdata_i;
        end
        if (sw_hit && sw_idx_i == IDX_ADDR) regs_o[g].addr <= sw_wdata_i;
      end
    end
  end
endmodule

// File: rtl/dma_req_engine.sv
module dma_req_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chan_regs_t        regs_i [NUM_CH],
  input  logic              req_valid_i,
  input  logic [CW-1:0]     req_chan_i,
  input  logic [DATA_W-1:0] req_len_i,
  input  logic              req_to_mem_i,
  input  logic              mem_done_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_len_o,
  output logic              mem_write_o,
  output logic              eng_we_o,
  output logic [CW-1:0]     eng_chan_o,
  output logic [DATA_W-1:0] eng_ctrl_o,
  output logic [DATA_W-1:0] eng_count_o,
  output logic [NUM_CH-1:0] nmi_src_o
);
  typedef enum logic {S_IDLE, S_BURST} state_e;

  state_e            state_q;
  logic [CW-1:0]     cur_chan_q;
  chan_regs_t        sel, cur;
  logic              accept, chan_ok, finish;
  logic [DATA_W-1:0] clamp_len;

  assign sel    = regs_i[req_chan_i];
  assign cur    = regs_i[cur_chan_q];
  assign accept = req_valid_i && (state_q == S_IDLE);
  assign finish = mem_done_i && (state_q == S_BURST);
  assign chan_ok = sel.ctrl[CTRL_EN] && (req_to_mem_i == !sel.ctrl[CTRL_DIR]);
  assign clamp_len = (req_len_i > sel.count) ? sel.count : req_len_i;

  always_comb begin
    eng_we_o    = 1'b0;
    eng_chan_o  = req_chan_i;
    eng_ctrl_o  = sel.ctrl;
    eng_count_o = sel.count;
    if (accept) begin
      eng_we_o   = 1'b1;
      eng_ctrl_o = sel.ctrl & ~STATUS_MASK;
      if (!chan_ok) eng_ctrl_o[CTRL_MERR] = 1'b1;
    end else if (finish) begin
      eng_we_o    = 1'b1;
      eng_chan_o  = cur_chan_q;
      eng_ctrl_o  = cur.ctrl;
      eng_ctrl_o[CTRL_TC] = 1'b1;
      eng_count_o = cur.count - mem_len_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cur_chan_q  <= '0;
      mem_addr_o  <= '0;
      mem_len_o   <= '0;
      mem_write_o <= 1'b0;
      nmi_src_o   <= '0;
    end else begin
      if (accept && chan_ok) begin
        state_q     <= S_BURST;
        cur_chan_q  <= req_chan_i;
        mem_addr_o  <= sel.addr;
        mem_len_o   <= clamp_len;
        mem_write_o <= req_to_mem_i;
      end
      if (accept && !chan_ok) nmi_src_o[req_chan_i] <= 1'b1;
      if (finish) state_q <= S_IDLE;
    end
  end

  assign busy_o = (state_q == S_BURST);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned AW     = 12,
  localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [CW-1:0]     req_chan_i,
  input  logic [DATA_W-1:0] req_len_i,
  input  logic              req_to_mem_i,
  output logic              busy_o,
  output logic              mem_valid_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_len_o,
  output logic              mem_write_o,
  input  logic              mem_done_i
);
  localparam logic [AW-1:0] NMI_OFS = AW'(12'h200);

  chan_regs_t        regs [NUM_CH];
  logic              eng_we;
  logic [CW-1:0]     eng_chan;
  logic [DATA_W-1:0] eng_ctrl, eng_count;
  logic [NUM_CH-1:0] nmi_src;

  logic [2:0]    ch_field;
  logic [1:0]    idx_field;
  logic          ch_hit, nmi_hit;
  logic [CW-1:0] sw_chan;
  logic          unused_addr_bits;

  assign ch_field  = reg_addr_i[7:5];
  assign idx_field = reg_addr_i[4:3];
  assign ch_hit    = (reg_addr_i[AW-1:8] == (AW-8)'(1)) && (int'(ch_field) < NUM_CH);
  assign nmi_hit   = (reg_addr_i[AW-1:3] == NMI_OFS[AW-1:3]);
  assign sw_chan   = ch_field[CW-1:0];
  assign unused_addr_bits = ^reg_addr_i[2:0];

  dma_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (reg_we_i && ch_hit),
    .sw_chan_i   (sw_chan),
    .sw_idx_i    (idx_field),
    .sw_wdata_i  (reg_wdata_i),
    .eng_we_i    (eng_we),
    .eng_chan_i  (eng_chan),
    .eng_ctrl_i  (eng_ctrl),
    .eng_count_i (eng_count),
    .regs_o      (regs)
  );

  dma_req_engine #(.NUM_CH(NUM_CH)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .regs_i       (regs),
    .req_valid_i  (req_valid_i),
    .req_chan_i   (req_chan_i),
    .req_len_i    (req_len_i),
    .req_to_mem_i (req_to_mem_i),
    .mem_done_i   (mem_done_i),
    .busy_o       (busy_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_write_o  (mem_write_o),
    .eng_we_o     (eng_we),
    .eng_chan_o   (eng_chan),
    .eng_ctrl_o   (eng_ctrl),
    .eng_count_o  (eng_count),
    .nmi_src_o    (nmi_src)
  );

  assign mem_valid_o = busy_o;

  always_comb begin
    reg_rdata_o = '0;
    if (ch_hit) begin
      unique case (idx_field)
        IDX_CTRL:  reg_rdata_o = regs[sw_chan].ctrl;
        IDX_COUNT: reg_rdata_o = regs[sw_chan].count;
        IDX_ADDR:  reg_rdata_o = regs[sw_chan].addr;
        default:   reg_rdata_o = '0;
      endcase
    end else if (nmi_hit) begin
      reg_rdata_o = DATA_W'(nmi_src);
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              mem_done_i,
  input logic              req_valid_i,
  input logic [31:0]       req_len_i,
  input logic [31:0]       mem_addr_o,
  input logic [31:0]       mem_len_o,
  input logic [NUM_CH-1:0] nmi_src
);
  assert_start_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_done_ends_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_done_i) |=> !busy_o);

  assert_burst_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_len_o)));

  assert_len_clamped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_len_o <= $past(req_len_i)));

  assert_nmi_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nmi_src & $past(nmi_src)) == $past(nmi_src)));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_done_i  (mem_done_i),
  .req_valid_i (req_valid_i),
  .req_len_i   (req_len_i),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .nmi_src     (nmi_src)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic [31:0] req_len = '0;
  logic        req_to_mem = 1'b0;
  logic        busy, mem_valid, mem_write;
  logic [31:0] mem_addr, mem_len;
  logic        mem_done = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_nmi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_chan_i(req_chan), .req_len_i(req_len), .req_to_mem_i(req_to_mem),
    .busy_o(busy), .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_write_o(mem_write), .mem_done_i(mem_done)
  );

  typedef struct packed {
    logic [2:0]  chan;
    logic [31:0] ctrl;
    logic [31:0] count;
    logic [31:0] addr;
    logic [31:0] len;
    logic        to_mem;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h0000_0001, 32'd100,      32'h0000_1000, 32'd40,     1'b1},
    '{3'd3, 32'h0000_0003, 32'd16,       32'h0002_0040, 32'd64,     1'b0},
    '{3'd5, 32'h0000_0000, 32'd10,       32'h0000_3000, 32'd5,      1'b1},
    '{3'd7, 32'h0000_0001, 32'd20,       32'h0000_4000, 32'd4,      1'b0},
    '{3'd2, 32'h0000_0703, 32'd8,        32'h8000_0010, 32'd8,      1'b0},
    '{3'd6, 32'h0000_0702, 32'd30,       32'h0000_5000, 32'd3,      1'b0},
    '{3'd1, 32'h0000_0001, 32'd0,        32'h0000_6000, 32'd12,     1'b1},
    '{3'd4, 32'h0000_0401, 32'h0001_0000, 32'h0000_7000, 32'h0000_FFFF, 1'b1}
  };

  function automatic logic [11:0] ofs(input int c, input int k);
    return 12'(12'h100 + c*32 + k*8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic request(input logic [2:0] c, input logic [31:0] l, input logic tm);
    @(negedge clk);
    req_valid = 1'b1; req_chan = c; req_len = l; req_to_mem = tm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic ok;
    logic [31:0] elen, ectrl;
    string tag;

    // R2: reset state
    repeat (2) @(negedge clk);
    chk("R2 busy in reset", 32'(busy), 32'd0);
    rd(ofs(0, 1), d); chk("R2 ctrl ch0 in reset", d, 32'd0);
    rst_ni = 1'b1;
    rd(ofs(7, 3), d); chk("R2 addr ch7 after reset", d, 32'd0);
    rd(12'h200, d);   chk("R2 nmi after reset", d, 32'd0);
    chk("R2 mem_valid after reset", 32'(mem_valid), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      wr(ofs(v.chan, 1), v.ctrl);
      wr(ofs(v.chan, 2), v.count);
      wr(ofs(v.chan, 3), v.addr);
      ok    = v.ctrl[0] && (v.to_mem == !v.ctrl[1]);
      elen  = (v.len > v.count) ? v.count : v.len;
      ectrl = v.ctrl & ~32'h700;
      request(v.chan, v.len, v.to_mem);
      if (ok) begin
        chk("R9 busy after accept", 32'(busy), 32'd1);
        chk("R9 mem_valid after accept", 32'(mem_valid), 32'd1);
        chk("R7 burst address", mem_addr, v.addr);
        chk("R6 clamped length", mem_len, elen);
        chk("R11 burst direction", 32'(mem_write), 32'(v.to_mem));
        rd(ofs(v.chan, 1), d); chk("R3 status cleared at accept", d, ectrl);
        done_pulse();
        chk("R9 busy after done", 32'(busy), 32'd0);
        rd(ofs(v.chan, 1), d); chk("R8 ctrl after done", d, ectrl | 32'h100);
        rd(ofs(v.chan, 2), d); chk("R8 count after done", d, v.count - elen);
        rd(ofs(v.chan, 3), d); chk("R7 addr not advanced", d, v.addr);
      end else begin
        tag = v.ctrl[0] ? "R5" : "R4";
        exp_nmi[v.chan] = 1'b1;
        chk({tag, " no burst"}, 32'(mem_valid), 32'd0);
        rd(ofs(v.chan, 1), d); chk({tag, " memory error flag"}, d, ectrl | 32'h200);
        rd(12'h200, d);        chk({tag, " error source bit"}, d, 32'(exp_nmi));
        rd(ofs(v.chan, 2), d); chk({tag, " count untouched"}, d, v.count);
      end
    end

    // R1: reserved word, unmapped offset, readback
    wr(ofs(2, 0), 32'hDEAD_BEEF);
    rd(ofs(2, 0), d); chk("R1 word 0 reads zero", d, 32'd0);
    rd(ofs(2, 3), d); chk("R1 word 0 write ignored", d, 32'h8000_0010);
    wr(ofs(3, 2), 32'h1234_5678);
    rd(ofs(3, 2), d); chk("R1 count readback", d, 32'h1234_5678);
    rd(12'h300, d);   chk("R1 unmapped reads zero", d, 32'd0);

    // R10: error-source register ignores writes
    wr(12'h200, 32'h0);
    rd(12'h200, d); chk("R10 write to 0x200 ignored", d, 32'(exp_nmi));

    // R9: request while busy is ignored
    wr(ofs(0, 1), 32'h1); wr(ofs(0, 2), 32'd50); wr(ofs(0, 3), 32'h0000_9000);
    wr(ofs(1, 1), 32'h0);
    request(3'd0, 32'd10, 1'b1);
    request(3'd1, 32'd4, 1'b1);
    chk("R9 still busy on first burst", 32'(busy), 32'd1);
    chk("R9 burst unchanged", mem_addr, 32'h0000_9000);
    rd(12'h200, d);   chk("R9 busy request raised no error", d, 32'(exp_nmi));
    rd(ofs(1, 1), d); chk("R9 busy request left ch1 alone", d, 32'd0);
    done_pulse();
    rd(ofs(0, 2), d); chk("R8 count after busy test", d, 32'd40);

    // R2: reset in the middle of a burst
    request(3'd0, 32'd5, 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R2 busy cleared by reset", 32'(busy), 32'd0);
    rd(ofs(0, 2), d); chk("R2 count cleared by reset", d, 32'd0);
    rd(12'h200, d);   chk("R2 nmi cleared by reset", d, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule